// File: doc/BRIEF.md
# Set-Bit Lane Commit Unit

This block serves a multi-lane machine that fetches one instruction per lane each cycle. Every instruction carries a single grouping bit. Neighbouring instructions with the same bit value belong to one parallel group, and a change in the value opens a new group. The unit looks only at the grouping bits of the lanes fetched this cycle. From them it works out which lanes belong to the group that starts at lane 0. Those lanes may commit their results, and their number is the amount by which the program counter advances.

The unit is purely combinational. Each lane after the first has a permission line that stays high until a grouping-bit change pulls it low. A change at any lane pulls down that lane's line and every line after it, so the permission lines form a prefix AND of the neighbour comparisons. The surviving lines give a commit mask. A line that is high while the next one is low marks the last committing lane, and that lane position gives the step count. The lane count is a parameter of at least two. A second parameter chooses how the prefix AND is built: as a serial ripple, or as a flat per-lane AND with a shallower path.

Top module: `setbit_commit`

## Requirements
- R1: Bit 0 of `commit_mask` is 1 for every input pattern.
- R2: For lane i ≥ 1, `commit_mask[i]` is 1 exactly when `set_bits[0]` through `set_bits[i]` all hold the same value.
- R3: When `set_bits[i]` differs from `set_bits[i-1]`, `commit_mask` is 0 for lane i and for every higher lane, even where later neighbours match each other.
- R4: `commit_count` is an unsigned binary number equal to the number of 1 bits in `commit_mask`. Its range is 1 to LANES and its width is clog2(LANES+1).
- R5: `commit_count` equals the index of the highest committing lane plus one, which is the program counter step.
- R6: `commit_mask` is always of the form 2^k−1 with 1 ≤ k ≤ LANES, a run of ones that starts at bit 0.
- R7: The ripple variant (CHAIN = CHAIN_RIPPLE) and the flat variant (CHAIN = CHAIN_FLAT) produce identical outputs for every input.
- R8: An input of all zeros and an input of all ones each give a full mask and a count of LANES, because only changes in the bit matter and not its value.
- R9: The outputs depend only on the current `set_bits`. A new input value appears on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_bits | input | LANES | Grouping bit of the instruction in each lane; bit 0 is the first lane |
| commit_mask | output | LANES | 1 for each lane allowed to commit this cycle |
| commit_count | output | clog2(LANES+1) | Number of committing lanes, used as the program counter step |

## Verification
Both results are combinational, so they are due in the same cycle as the stimulus and have no register stage. The bench changes `set_bits` one time unit after a rising edge and reads both outputs at the following falling edge. By then any change has settled, and the reading stays clear of the edge where the next input is driven. Every pattern of an eight-lane ripple instance and a five-lane flat instance is applied. For each pattern the expected mask and count come from a scan for the first grouping-bit change.

// File: rtl/setbit_pkg.sv
package setbit_pkg;
   typedef enum logic [0:0] {
      CHAIN_RIPPLE = 1'b0,
      CHAIN_FLAT   = 1'b1
   } chain_kind_e;
endpackage

// File: rtl/setbit_neighbour_cmp.sv
module setbit_neighbour_cmp #(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0] set_bits,
   output logic [LANES-2:0] same_as_prev
);
   // same_as_prev[k] relates lane k+1 to lane k
   for (genvar k = 0; k < LANES-1; k++) begin : g_cmp
      assign same_as_prev[k] = ~(set_bits[k+1] ^ set_bits[k]);
   end
endmodule

// File: rtl/setbit_kill_chain.sv
module setbit_kill_chain #(
   parameter int                      LANES = 8,
   parameter setbit_pkg::chain_kind_e CHAIN = setbit_pkg::CHAIN_RIPPLE
) (
   input  logic [LANES-2:0] same_as_prev,
   output logic [LANES-2:0] alive_line
);
   if (CHAIN == setbit_pkg::CHAIN_RIPPLE) begin : g_ripple
      assign alive_line[0] = same_as_prev[0];
      for (genvar k = 1; k < LANES-1; k++) begin : g_link
         assign alive_line[k] = alive_line[k-1] & same_as_prev[k];
      end
   end else begin : g_flat
      for (genvar k = 0; k < LANES-1; k++) begin : g_and
         assign alive_line[k] = &same_as_prev[k:0];
      end
   end

   // a pulled-down line stays down for every later lane
   always_comb begin
      for (int k = 0; k < LANES-1; k++) begin
         if (!same_as_prev[k])
            assert_kill_R3: assert (alive_line[k] == 1'b0)
               else $error("line %0d alive after mismatch", k);
         if (k > 0 && !alive_line[k-1])
            assert_kill_spreads_R3: assert (alive_line[k] == 1'b0)
               else $error("line %0d alive after earlier kill", k);
      end
   end
endmodule

// File: rtl/setbit_step_encode.sv
module setbit_step_encode #(
   parameter int LANES = 8,
   localparam int CNT_W = $clog2(LANES+1)
) (
   input  logic [LANES-2:0] alive_line,
   output logic [CNT_W-1:0] step
);
   logic [LANES:0]   ext_line;
   logic [LANES-1:0] last_lane;

   // lane 0 is always alive, a virtual lane past the end never is
   assign ext_line = {1'b0, alive_line, 1'b1};

   for (genvar i = 0; i < LANES; i++) begin : g_last
      assign last_lane[i] = ext_line[i] & ~ext_line[i+1];
   end

   always_comb begin
      step = '0;
      for (int i = 0; i < LANES; i++) begin
         if (last_lane[i]) step = step | CNT_W'(i+1);
      end
   end

   always_comb begin
      assert_one_last_R5: assert ($onehot(last_lane))
         else $error("last-lane marker not one-hot: %b", last_lane);
      assert_step_matches_R4: assert (32'(step) == 32'($countones(ext_line)))
         else $error("step %0d vs live lines %b", step, ext_line);
   end
endmodule

// File: rtl/setbit_commit.sv
module setbit_commit #(
   parameter int                      LANES = 8,
   parameter setbit_pkg::chain_kind_e CHAIN = setbit_pkg::CHAIN_RIPPLE,
   localparam int                     CNT_W = $clog2(LANES+1)
) (
   input  logic [LANES-1:0] set_bits,
   output logic [LANES-1:0] commit_mask,
   output logic [CNT_W-1:0] commit_count
);
   if (LANES < 2) begin : g_bad_lanes
      $error("setbit_commit needs LANES >= 2, got %0d", LANES);
   end

   logic [LANES-2:0] same_as_prev;
   logic [LANES-2:0] alive_line;

   setbit_neighbour_cmp #(.LANES(LANES)) u_cmp (
      .set_bits     (set_bits),
      .same_as_prev (same_as_prev)
   );

   setbit_kill_chain #(.LANES(LANES), .CHAIN(CHAIN)) u_chain (
      .same_as_prev (same_as_prev),
      .alive_line   (alive_line)
   );

   setbit_step_encode #(.LANES(LANES)) u_step (
      .alive_line (alive_line),
      .step       (commit_count)
   );

   assign commit_mask = {alive_line, 1'b1};

   always_comb begin
      assert_lane0_R1: assert (commit_mask[0] == 1'b1)
         else $error("lane 0 not committing");
      assert_contiguous_R6: assert ((commit_mask & (commit_mask + 1'b1)) == '0)
         else $error("mask not a prefix run: %b", commit_mask);
      assert_count_range_R4: assert (commit_count >= 1 && 32'(commit_count) <= LANES)
         else $error("count %0d out of range", commit_count);
      for (int i = 1; i < LANES; i++) begin
         if (commit_mask[i])
            assert_same_group_R2: assert (set_bits[i] == set_bits[0])
               else $error("lane %0d commits from another group", i);
      end
   end
endmodule

// File: tb/sim_setbit_commit.sv
module sim_setbit_commit;
   localparam int NA = 8;
   localparam int NB = 5;
   localparam int WA = $clog2(NA+1);
   localparam int WB = $clog2(NB+1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [NA-1:0] bits_a = '0;
   logic [NA-1:0] mask_a;
   logic [WA-1:0] cnt_a;
   logic [NB-1:0] bits_b = '0;
   logic [NB-1:0] mask_b;
   logic [WB-1:0] cnt_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   setbit_commit #(.LANES(NA), .CHAIN(setbit_pkg::CHAIN_RIPPLE)) u0 (
      .set_bits(bits_a), .commit_mask(mask_a), .commit_count(cnt_a));
   setbit_commit #(.LANES(NB), .CHAIN(setbit_pkg::CHAIN_FLAT)) u1 (
      .set_bits(bits_b), .commit_mask(mask_b), .commit_count(cnt_b));

   function automatic int run_len(input logic [31:0] b, input int n);
      int k = 1;
      while (k < n && b[k] == b[k-1]) k++;
      return k;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic sweep_a(input int p);
      int k;
      @(posedge clk); #1 bits_a = NA'(p);
      @(negedge clk);
      k = run_len(32'(p), NA);
      check("R2_R3_R6 mask_a", int'(mask_a), (1 << k) - 1);
      check("R4_R5 count_a", int'(cnt_a), k);
      check("R1 lane0_a", int'(mask_a[0]), 1);
   endtask

   task automatic sweep_b(input int p);
      int k;
      @(posedge clk); #1 bits_b = NB'(p);
      @(negedge clk);
      k = run_len(32'(p), NB);
      check("R7 mask_b flat", int'(mask_b), (1 << k) - 1);
      check("R7 count_b flat", int'(cnt_b), k);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // idle state: all-zero input gives full commit (R8)
      check("R8 zeros mask_a", int'(mask_a), (1 << NA) - 1);
      check("R8 zeros count_a", int'(cnt_a), NA);
      // R9: change input and read within the same cycle
      @(posedge clk); #1 bits_a = 8'b0000_0010;
      #2 check("R9 same-cycle count", int'(cnt_a), 1);
      // R3: kill at lane 2 despite matching lanes above
      @(posedge clk); #1 bits_a = 8'b1111_1100;
      @(negedge clk);
      check("R3 late matches ignored", int'(mask_a), 3);
      @(posedge clk); #1 bits_a = 8'hFF;
      @(negedge clk);
      check("R8 ones mask_a", int'(mask_a), 255);
      check("R8 ones count_a", int'(cnt_a), NA);
      for (int p = 0; p < (1 << NA); p++) sweep_a(p);
      for (int p = 0; p < (1 << NB); p++) sweep_b(p);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule